// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block watches the UP and DOWN pulses of a phase-frequency detector, sampled on a fast clock, and decides whether the loop is locked. Each detector cycle lasts from the first sample where either pulse is high until the first sample where both are low again. The phase error of that cycle is the width of the wider pulse, counted in sample-clock periods.

Lock is declared only after a run of consecutive detector cycles whose error stays under a tight threshold. The run length is 3 or 5, chosen by a precision input. Once declared, lock is lost only when a cycle's error exceeds a second, looser threshold. This gives hysteresis: a cycle whose error falls between the two thresholds restarts the run but leaves an existing lock in place. An error that grows past the loose threshold drops lock at once, even while the pulse is still high.

A synchronous power-down input clears the lock and any measurement in progress. Both thresholds are inputs, so software can set them to match the sample-clock period.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset `locked` is 0. `locked` is active high.
- R2: A detector cycle's error is max(UP width, DOWN width), where each width is the number of clock edges at which that input was sampled high. A cycle ends at the first edge where both inputs are sampled low.
- R3: With `prec_sel`=0, `locked` rises at the end of the 3rd consecutive cycle whose error is strictly below `lock_thr`.
- R4: With `prec_sel`=1, `locked` rises at the end of the 5th such consecutive cycle.
- R5: A cycle whose error is strictly above `unlock_thr` clears `locked` and restarts the good-cycle run.
- R6: When a pulse is still high, `locked` drops at the edge after the sampled width first exceeds `unlock_thr`, without waiting for the cycle to end.
- R7: A cycle whose error lies in [`lock_thr`, `unlock_thr`] restarts the good-cycle run and leaves `locked` unchanged.
- R8: The good-cycle count saturates at the required run length. Once `locked` is set, further good cycles keep it at 1.
- R9: `pwr_dn`=1 clears `locked`, the run and the width measurement. After `pwr_dn` is released, a full run is needed again.
- R10: `locked` changes at the same clock edge that samples the end of the cycle, so it is visible one clock after the last high sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Synchronous power-down / counter clear |
| pd_up | input | 1 | UP pulse from the phase detector, synchronous to clk |
| pd_dn | input | 1 | DOWN pulse from the phase detector, synchronous to clk |
| prec_sel | input | 1 | 0: run of 3 good cycles, 1: run of 5 |
| lock_thr | input | CNT_W | Error must be below this value, in samples, to count as good |
| unlock_thr | input | CNT_W | Error above this value, in samples, drops lock |
| locked | output | 1 | Lock flag, active high |

## Verification
The assertions assume that `prec_sel` changes only while the run is cleared, that is, one cycle after `pwr_dn` is raised. They also assume that `pd_up` and `pd_dn` are already synchronous to `clk`. The bench follows both rules: it raises `pwr_dn`, waits a cycle, changes the precision, and only then releases `pwr_dn`. It also drives the pulses only on falling edges. In the sweep, each width pair is preceded by a power-down and a fixed locking preamble, so every pair starts from a known state.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int RUN_W        = 3;
  localparam int RUN_FAST     = 3;
  localparam int RUN_PRECISE  = 5;

  function automatic logic [RUN_W-1:0] run_target(input logic precise);
    return precise ? RUN_W'(RUN_PRECISE) : RUN_W'(RUN_FAST);
  endfunction
endpackage

// File: rtl/plm_width_meter.sv
module plm_width_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pulse,
  input  logic             busy,
  output logic [CNT_W-1:0] width
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      width <= '0;
    else if (clr)                    width <= '0;
    else if (pulse && width != MAXV) width <= width + 1'b1;
    else if (!busy)                  width <= '0;
  end
endmodule

// File: rtl/plm_cycle_tracker.sv
module plm_cycle_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             busy,
  input  logic [CNT_W-1:0] w_up,
  input  logic [CNT_W-1:0] w_dn,
  output logic             cyc_end,
  output logic [CNT_W-1:0] err
);
  logic active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   active_q <= 1'b0;
    else if (clr) active_q <= 1'b0;
    else          active_q <= busy;
  end

  always_comb begin
    cyc_end = active_q && !busy;
    err     = (w_up > w_dn) ? w_up : w_dn;
  end
endmodule

// File: rtl/plm_lock_fsm.sv
module plm_lock_fsm
  import plm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             precise,
  input  logic             cyc_end,
  input  logic [CNT_W-1:0] err,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] unlock_thr,
  output logic [RUN_W-1:0] run,
  output logic             locked
);
  logic [RUN_W-1:0] need;
  logic [RUN_W-1:0] run_inc;
  logic             too_big;
  logic             good;

  always_comb begin
    need    = run_target(precise);
    run_inc = run + 1'b1;
    too_big = err > unlock_thr;
    good    = err < lock_thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (clr || too_big) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (cyc_end) begin
      if (good) begin
        if (run < need)     run    <= run_inc;
        if (run_inc >= need) locked <= 1'b1;
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             pd_up,
  input  logic             pd_dn,
  input  logic             prec_sel,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] unlock_thr,
  output logic             locked
);
  localparam int RUN_W = plm_pkg::RUN_W;

  logic                   busy;
  logic [1:0]             pulses;
  logic [1:0][CNT_W-1:0]  widths;
  logic                   cyc_end;
  logic [CNT_W-1:0]       err_max;
  logic [RUN_W-1:0]       run_cnt;

  assign busy   = pd_up | pd_dn;
  assign pulses = {pd_dn, pd_up};

  for (genvar ch = 0; ch < 2; ch++) begin : g_meter
    plm_width_meter #(.CNT_W(CNT_W)) u_meter (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (pwr_dn),
      .pulse(pulses[ch]),
      .busy (busy),
      .width(widths[ch])
    );
  end

  plm_cycle_tracker #(.CNT_W(CNT_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (pwr_dn),
    .busy   (busy),
    .w_up   (widths[0]),
    .w_dn   (widths[1]),
    .cyc_end(cyc_end),
    .err    (err_max)
  );

  plm_lock_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (pwr_dn),
    .precise   (prec_sel),
    .cyc_end   (cyc_end),
    .err       (err_max),
    .lock_thr  (lock_thr),
    .unlock_thr(unlock_thr),
    .run       (run_cnt),
    .locked    (locked)
  );
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int CNT_W = 8,
  parameter int RUN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_dn,
  input logic             prec_sel,
  input logic [CNT_W-1:0] unlock_thr,
  input logic [CNT_W-1:0] err,
  input logic [RUN_W-1:0] run,
  input logic             locked
);
  logic [RUN_W-1:0] need;
  assign need = prec_sel ? RUN_W'(5) : RUN_W'(3);

  assert_pwrdn_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !locked);

  assert_big_err_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err > unlock_thr) |=> !locked);

  assert_run_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
    run <= need);

  assert_rise_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
    $rose(locked) |-> run == need);

  assert_fall_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(pwr_dn) || $past(err) > $past(unlock_thr)));
endmodule

bind pll_lock_monitor plm_checker #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_dn    (pwr_dn),
  .prec_sel  (prec_sel),
  .unlock_thr(unlock_thr),
  .err       (err_max),
  .run       (run_cnt),
  .locked    (locked)
);

// File: tb/sim_pll_lock_monitor.sv
module sim_pll_lock_monitor;
  localparam int CNT_W = 6;
  localparam int LT    = 4;
  localparam int UT    = 8;

  logic clk = 1'b0, rst_n = 1'b0, pwr_dn = 1'b0, pd_up = 1'b0, pd_dn = 1'b0, prec_sel = 1'b0;
  logic [CNT_W-1:0] lock_thr = CNT_W'(LT), unlock_thr = CNT_W'(UT);
  logic locked;

  int checks = 0, errors = 0;
  int m_run = 0, m_lock = 0;

  always #10 clk = ~clk;

  pll_lock_monitor #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .pd_up(pd_up), .pd_dn(pd_dn),
    .prec_sel(prec_sel), .lock_thr(lock_thr), .unlock_thr(unlock_thr), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic power_cycle(input logic prec);
    @(negedge clk) pwr_dn = 1'b1;
    @(negedge clk) prec_sel = prec;
    @(negedge clk) pwr_dn = 1'b0;
    m_run = 0; m_lock = 0;
  endtask

  // one detector cycle: UP high for wu samples, DOWN high for wd samples
  task automatic det_cycle(input int wu, input int wd, input string req);
    int e, need;
    e    = (wu > wd) ? wu : wd;
    need = prec_sel ? 5 : 3;
    for (int i = 0; i < e; i++) begin
      @(negedge clk);
      pd_up = (i < wu);
      pd_dn = (i < wd);
    end
    @(negedge clk) begin pd_up = 1'b0; pd_dn = 1'b0; end
    if (e > UT) begin m_run = 0; m_lock = 0; end
    else if (e < LT) begin
      if (m_run < need) m_run++;
      if (m_run >= need) m_lock = 1;
    end else m_run = 0;
    @(negedge clk);
    chk(req, int'(locked), m_lock);
  endtask

  initial begin
    lock_thr = CNT_W'(LT); unlock_thr = CNT_W'(UT);
    repeat (3) @(negedge clk);
    chk("R1 reset", int'(locked), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", int'(locked), 0);

    // R3: three good cycles needed with prec_sel=0
    power_cycle(1'b0);
    det_cycle(1, 2, "R3 good#1");
    det_cycle(3, 1, "R3 good#2");
    det_cycle(2, 2, "R3 good#3");
    chk("R3 locked after 3", int'(locked), 1);
    det_cycle(1, 1, "R8 stays locked");
    det_cycle(1, 3, "R8 stays locked");
    det_cycle(6, 2, "R7 mid keeps lock");
    chk("R7 lock kept", int'(locked), 1);
    det_cycle(9, 1, "R5 big drops lock");
    chk("R5 unlocked", int'(locked), 0);

    // R4: five with prec_sel=1, R7 middle resets run
    power_cycle(1'b1);
    for (int k = 0; k < 4; k++) det_cycle(2, 1, "R4 before 5");
    chk("R4 not yet", int'(locked), 0);
    det_cycle(LT, 0, "R7 mid resets run");
    for (int k = 0; k < 4; k++) det_cycle(1, 2, "R4 restart");
    chk("R4 still not", int'(locked), 0);
    det_cycle(1, 1, "R4 fifth");
    chk("R4 locked after 5", int'(locked), 1);

    // R10: latency of the rise
    power_cycle(1'b0);
    det_cycle(1, 1, "R10 pre1");
    det_cycle(1, 1, "R10 pre2");
    @(negedge clk) pd_up = 1'b1;
    @(negedge clk) begin pd_up = 1'b0; chk("R10 before end sample", int'(locked), 0); end
    @(negedge clk) chk("R10 after end sample", int'(locked), 1);
    m_run = 3; m_lock = 1;

    // R6: drop while pulse still high
    for (int i = 0; i < UT + 4; i++) begin
      @(negedge clk);
      if (i == UT + 1) chk("R6 still locked", int'(locked), 1);
      if (i == UT + 2) chk("R6 dropped mid-pulse", int'(locked), 0);
      pd_dn = 1'b1;
    end
    @(negedge clk) pd_dn = 1'b0;
    @(negedge clk);
    m_run = 0; m_lock = 0;

    // R9: power-down clears lock, full run needed again
    for (int k = 0; k < 3; k++) det_cycle(1, 1, "R9 relock");
    @(negedge clk) begin pwr_dn = 1'b1; pd_up = 1'b1; end
    @(negedge clk) chk("R9 cleared", int'(locked), 0);
    @(negedge clk) begin pwr_dn = 1'b0; pd_up = 1'b0; end
    m_run = 0; m_lock = 0;
    det_cycle(1, 1, "R9 after pd 1");
    det_cycle(1, 1, "R9 after pd 2");
    chk("R9 not yet", int'(locked), 0);
    det_cycle(1, 1, "R9 after pd 3");

    // R2 sweep: every width pair, from a locked state
    for (int p = 0; p < 2; p++) begin
      for (int wu = 0; wu <= 10; wu++) begin
        for (int wd = 0; wd <= 10; wd++) begin
          if (wu + wd != 0) begin
            power_cycle(p[0]);
            for (int k = 0; k < 5; k++) det_cycle(2, 1, "R2 preamble");
            det_cycle(wu, wd, "R2 R5 R7 width pair");
            det_cycle(1, 1, "R2 follow-up");
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1-run actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule